// File: doc/BRIEF.md
# Receive Frame Task Sequencer

This block is the receive-side controller of a packet radio data pump. A demodulator delivers a serial bit stream with a bit-clock strobe and a carrier-detect level. A host steers reception one task at a time through a small register interface: a task write, a status read with sticky flags, a byte buffer with a read strobe, and an interrupt line.

The host first loads a 16-bit frame sync pattern as two byte writes. Shortly after carrier detect it starts an acquisition task, which deserialises bytes into the buffer. That task also drives the level-acquire and clock-acquire control outputs. The task finishes once the host has taken two bytes out of the buffer.

The host then starts a header search. This task hunts for the sync pattern, decodes a three-byte frame head and reports a frame-type flag and a header-check flag. Next the host starts one or more data-block tasks. Each one collects a fixed number of bytes and checks their CRC. Every task ends with an interrupt and a return to idle. Any new task write aborts the running task. Loss of carrier also aborts it.

Top module: `rx_task_seq`

## Requirements
- R1: After reset, irq, all status flags and both acquisition control outputs are 0, and the byte buffer is empty.
- R2: Each sync_wr shifts sync_byte into the low end of the pattern, so the first byte written becomes the high byte. The high byte is the one expected first on air, with bits arriving MSB first.
- R3: Bits are sampled only in cycles where bit_stb is high. A task write (task_code 0 = stop, 1 = acquire, 2 = header search, 3 = data block) takes effect at the next bit_stb and discards that strobe's bit. A running task is abandoned at that point.
- R4: The acquire task pushes every received byte into the buffer. It raises irq and ends when the second buffer read since the task started removes a byte. lev_acq and clk_acq copy task_lev and task_clk when an acquire task is written. They return to 0 when that task ends.
- R5: The header search compares the last 16 received bits with the sync pattern. After a match it takes three bytes, pushes the first two, and raises irq. st_ftype is bit 7 of the first byte. st_hdr_ok is 1 when the third byte equals the XOR of the first two.
- R6: The data-block task pushes exactly BLK_BYTES (18) bytes and raises irq. st_crc_ok is 1 when CRC-16 (polynomial 0x1021, initial value 0xFFFF, MSB first, no final XOR) over all the bytes is zero; the last two bytes carry the sender's CRC, high byte first.
- R7: When a task completes, the block goes idle on its own. Further bits raise no irq and push nothing.
- R8: A stat_rd pulse clears irq, st_underflow and st_carrier_lost. A completion in the same cycle leaves irq set.
- R9: A buf_rd on an empty buffer sets st_underflow and leaves buf_data unchanged. Otherwise each buf_rd presents the oldest byte on buf_data in the following cycle.
- R10: While carrier_det is low the block is idle. If a task was running when carrier dropped, st_carrier_lost is set and no irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_det | input | 1 | Carrier present level |
| bit_stb | input | 1 | One-cycle bit-clock strobe |
| bit_in | input | 1 | Demodulated data bit |
| sync_wr | input | 1 | Sync byte write strobe |
| sync_byte | input | 8 | Sync byte value |
| task_wr | input | 1 | Task write strobe |
| task_code | input | 2 | Task selector |
| task_lev | input | 1 | Level-acquire request with acquire task |
| task_clk | input | 1 | Clock-acquire request with acquire task |
| stat_rd | input | 1 | Status read strobe |
| buf_rd | input | 1 | Buffer read strobe |
| buf_data | output | 8 | Last byte read from buffer |
| irq | output | 1 | Task-complete interrupt |
| lev_acq | output | 1 | Level-acquire control |
| clk_acq | output | 1 | Clock-acquire control |
| st_ftype | output | 1 | Frame-type flag from header |
| st_hdr_ok | output | 1 | Header check valid |
| st_crc_ok | output | 1 | Data block CRC valid |
| st_underflow | output | 1 | Read of empty buffer (sticky) |
| st_carrier_lost | output | 1 | Task aborted by carrier loss (sticky) |

## Verification
The bench builds the block with its defaults: a 32-entry buffer, 18-byte blocks and a 16-bit sync. With that depth, an aborted block's three stray bytes plus a full following block (21 bytes) fit without loss. The bench can therefore prove that an abort restarts the byte count rather than merely carrying on. The 18-byte block length lets a correct and a corrupted block, each carrying its own CRC, exercise both outcomes of the zero-remainder check. Between strobes the bench drives the inverted bit, so any sampling off the strobe would corrupt every byte.

// File: rtl/rxs_pkg.sv
// Shared types and the CRC step for the receive task sequencer.
// Assumes MSB-first bit order on air.
package rxs_pkg;
    typedef enum logic [1:0] {
        TSK_STOP = 2'd0,
        TSK_ACQ  = 2'd1,
        TSK_SFH  = 2'd2,
        TSK_RDB  = 2'd3
    } task_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACQ, ST_SRCH, ST_HDR, ST_BLK
    } state_e;

    // Advances a CRC-16 (poly 0x1021) register by one byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction
endpackage

// File: rtl/rxs_deser.sv
// Serial-to-parallel shifter. Keeps the last W sampled bits and flags each
// sampled bit and each completed byte one cycle later.
// Assumes bit_en pulses are at least two cycles apart. clr realigns the byte
// phase without touching the bit window.
module rxs_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic [W-1:0] win,
    output logic         bit_done,
    output logic         byte_done
);
    logic [2:0] cnt_q;

    // Shift in sampled bits and count byte phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win       <= '0;
            cnt_q     <= '0;
            bit_done  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            bit_done  <= 1'b0;
            byte_done <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (bit_en) begin
                win       <= {win[W-2:0], bit_in};
                cnt_q     <= cnt_q + 3'd1;
                bit_done  <= 1'b1;
                byte_done <= (cnt_q == 3'd7);
            end
        end
    end

    // R3
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(win));
endmodule

// File: rtl/rxs_fifo.sv
// Byte buffer with registered read data. Pushes into a full buffer are
// dropped; pops from an empty one leave dout unchanged.
// Assumes DEPTH is a power of two.
module rxs_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          full, push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    // Store pushed bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= din;
    end

    // Track pointers, occupancy and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            dout  <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + AW'(1);
            if (pop_ok) begin
                rp_q <= rp_q + AW'(1);
                dout <= mem[rp_q];
            end
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(dout));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rx_task_seq.sv
// Receive task sequencer. Runs one host-selected task at a time: acquire,
// header search or data block. Each task ends with irq and a return to idle.
// Assumes bit_stb pulses are at least two cycles apart and that the sync
// pattern is loaded before a header search.
module rx_task_seq
    import rxs_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int BLK_BYTES  = 18,
    parameter int SYNC_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier_det,
    input  logic       bit_stb,
    input  logic       bit_in,
    input  logic       sync_wr,
    input  logic [7:0] sync_byte,
    input  logic       task_wr,
    input  logic [1:0] task_code,
    input  logic       task_lev,
    input  logic       task_clk,
    input  logic       stat_rd,
    input  logic       buf_rd,
    output logic [7:0] buf_data,
    output logic       irq,
    output logic       lev_acq,
    output logic       clk_acq,
    output logic       st_ftype,
    output logic       st_hdr_ok,
    output logic       st_crc_ok,
    output logic       st_underflow,
    output logic       st_carrier_lost
);
    localparam int CW = $clog2(BLK_BYTES + 1);

    state_e              st_q;
    task_e               pend_code_q;
    logic                pend_q, popcnt_q, ftype_p_q;
    logic [CW-1:0]       bcnt_q;
    logic [7:0]          ctrlx_q;
    logic [15:0]         crc_q, crc_nxt;
    logic [SYNC_W-1:0]   sync_q, win;
    logic                bit_done, byte_done, deser_clr, bit_en;
    logic                start_now, live, match, push, popped, buf_empty;
    logic                done_acq, done_hdr, done_blk, irq_set;
    logic [7:0]          rx_byte;

    assign start_now = bit_stb && pend_q && carrier_det;
    assign live      = carrier_det && !start_now;
    assign match     = bit_done && (win == sync_q);
    assign deser_clr = start_now || !carrier_det || (st_q == ST_SRCH && match);
    assign bit_en    = bit_stb && (st_q != ST_IDLE);
    assign rx_byte   = win[7:0];
    assign popped    = buf_rd && !buf_empty;
    assign crc_nxt   = crc16_byte(crc_q, rx_byte);
    assign push      = live && byte_done && (st_q == ST_ACQ || st_q == ST_BLK ||
                       (st_q == ST_HDR && bcnt_q < CW'(2)));
    assign done_acq  = live && st_q == ST_ACQ && popped && popcnt_q;
    assign done_hdr  = live && st_q == ST_HDR && byte_done && bcnt_q == CW'(2);
    assign done_blk  = live && st_q == ST_BLK && byte_done && bcnt_q == CW'(BLK_BYTES - 1);
    assign irq_set   = done_acq || done_hdr || done_blk;

    rxs_deser #(.W(SYNC_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .clr(deser_clr), .bit_en(bit_en),
        .bit_in(bit_in), .win(win), .bit_done(bit_done), .byte_done(byte_done)
    );

    rxs_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(rx_byte),
        .pop(buf_rd), .dout(buf_data), .empty(buf_empty)
    );

    // Load the sync pattern a byte at a time, first byte ending up on top.
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_q <= '0;
        else if (sync_wr) sync_q <= {sync_q[SYNC_W-9:0], sync_byte};
    end

    // Task state machine: pending task start, per-task byte handling, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_q      <= 1'b0;
            pend_code_q <= TSK_STOP;
            popcnt_q    <= 1'b0;
            bcnt_q      <= '0;
            ctrlx_q     <= '0;
            ftype_p_q   <= 1'b0;
            crc_q       <= 16'hFFFF;
        end else begin
            if (!carrier_det) begin
                st_q   <= ST_IDLE;
                pend_q <= 1'b0;
            end else if (start_now) begin
                pend_q   <= 1'b0;
                bcnt_q   <= '0;
                popcnt_q <= 1'b0;
                crc_q    <= 16'hFFFF;
                case (pend_code_q)
                    TSK_ACQ: st_q <= ST_ACQ;
                    TSK_SFH: st_q <= ST_SRCH;
                    TSK_RDB: st_q <= ST_BLK;
                    default: st_q <= ST_IDLE;
                endcase
            end else begin
                case (st_q)
                    ST_ACQ: begin
                        if (popped) popcnt_q <= 1'b1;
                        if (done_acq) st_q <= ST_IDLE;
                    end
                    ST_SRCH: if (match) begin
                        st_q   <= ST_HDR;
                        bcnt_q <= '0;
                    end
                    ST_HDR: if (byte_done) begin
                        bcnt_q <= bcnt_q + CW'(1);
                        if (bcnt_q == '0) begin
                            ctrlx_q   <= rx_byte;
                            ftype_p_q <= rx_byte[7];
                        end else if (bcnt_q == CW'(1)) begin
                            ctrlx_q <= ctrlx_q ^ rx_byte;
                        end
                        if (done_hdr) st_q <= ST_IDLE;
                    end
                    ST_BLK: if (byte_done) begin
                        crc_q  <= crc_nxt;
                        bcnt_q <= bcnt_q + CW'(1);
                        if (done_blk) st_q <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
            if (task_wr) begin
                pend_q      <= 1'b1;
                pend_code_q <= task_e'(task_code);
            end
        end
    end

    // Status flags, interrupt and acquisition controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq             <= 1'b0;
            st_ftype        <= 1'b0;
            st_hdr_ok       <= 1'b0;
            st_crc_ok       <= 1'b0;
            st_underflow    <= 1'b0;
            st_carrier_lost <= 1'b0;
            lev_acq         <= 1'b0;
            clk_acq         <= 1'b0;
        end else begin
            if (irq_set)      irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
            if (done_hdr) begin
                st_ftype  <= ftype_p_q;
                st_hdr_ok <= (rx_byte == ctrlx_q);
            end
            if (done_blk) st_crc_ok <= (crc_nxt == 16'h0000);
            if (buf_rd && buf_empty) st_underflow <= 1'b1;
            else if (stat_rd)        st_underflow <= 1'b0;
            if (!carrier_det && st_q != ST_IDLE) st_carrier_lost <= 1'b1;
            else if (stat_rd)                    st_carrier_lost <= 1'b0;
            if (task_wr) begin
                lev_acq <= (task_code == 2'd1) && task_lev;
                clk_acq <= (task_code == 2'd1) && task_clk;
            end else if (done_acq || !carrier_det) begin
                lev_acq <= 1'b0;
                clk_acq <= 1'b0;
            end
        end
    end

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (st_q == ST_IDLE));
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_rd));
    // R10
    carrier_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_det |=> (st_q == ST_IDLE));
    // R6
    blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLK) |-> (bcnt_q < CW'(BLK_BYTES)));
endmodule

// File: tb/tb_rx_task_seq.sv
module tb_rx_task_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier_det = 1'b1, bit_stb = 1'b0, bit_in = 1'b0;
    logic sync_wr = 1'b0, task_wr = 1'b0, task_lev = 1'b0, task_clk = 1'b0;
    logic stat_rd = 1'b0, buf_rd = 1'b0;
    logic [7:0] sync_byte = '0;
    logic [1:0] task_code = '0;
    logic [7:0] buf_data;
    logic irq, lev_acq, clk_acq, st_ftype, st_hdr_ok, st_crc_ok, st_underflow, st_carrier_lost;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] blk [18];

    always #2 clk = ~clk;

    rx_task_seq dut (
        .clk(clk), .rst_n(rst_n), .carrier_det(carrier_det), .bit_stb(bit_stb),
        .bit_in(bit_in), .sync_wr(sync_wr), .sync_byte(sync_byte), .task_wr(task_wr),
        .task_code(task_code), .task_lev(task_lev), .task_clk(task_clk),
        .stat_rd(stat_rd), .buf_rd(buf_rd), .buf_data(buf_data), .irq(irq),
        .lev_acq(lev_acq), .clk_acq(clk_acq), .st_ftype(st_ftype),
        .st_hdr_ok(st_hdr_ok), .st_crc_ok(st_crc_ok), .st_underflow(st_underflow),
        .st_carrier_lost(st_carrier_lost)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] a [18], input int n);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            r = r ^ {a[i], 8'h00};
            for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    // Inverted bit is driven between strobes to expose off-strobe sampling.
    task automatic send_bit(input logic b);
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; bit_in = ~b;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit expect_push);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        if (expect_push) exp_q.push_back(b);
    endtask

    task automatic wr_task(input logic [1:0] code, input logic lv, input logic ck);
        task_wr = 1'b1; task_code = code; task_lev = lv; task_clk = ck;
        @(negedge clk);
        task_wr = 1'b0; task_lev = 1'b0; task_clk = 1'b0;
        send_bit(1'b0);
    endtask

    task automatic read_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_byte();
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
    endtask

    // Monitor: pop the buffer and compare against the expected queue.
    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            rd_byte();
            chk(req, buf_data, e);
        end
    endtask

    task automatic fill_blk(input int seed);
        logic [15:0] c;
        for (int i = 0; i < 16; i++) blk[i] = 8'(i * 7 + seed);
        c = ref_crc(blk, 16);
        blk[16] = c[15:8];
        blk[17] = c[7:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 status", {st_ftype, st_hdr_ok, st_crc_ok, st_underflow, st_carrier_lost}, 0);
        chk("R1 acq ctl", {lev_acq, clk_acq}, 0);

        // R2 load sync A5 then 3C
        sync_wr = 1'b1; sync_byte = 8'hA5; @(negedge clk);
        sync_byte = 8'h3C; @(negedge clk);
        sync_wr = 1'b0;

        // R4 acquisition task
        wr_task(2'd1, 1'b1, 1'b1);
        chk("R4 acq ctl set", {lev_acq, clk_acq}, 3);
        send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
        chk("R4 no irq before reads", irq, 0);
        rd_byte(); chk("R4 first byte", buf_data, exp_q.pop_front());
        chk("R4 irq after one read", irq, 0);
        rd_byte(); chk("R4 second byte", buf_data, exp_q.pop_front());
        chk("R4 irq after second read", irq, 1);
        chk("R4 acq ctl cleared", {lev_acq, clk_acq}, 0);
        read_stat();
        chk("R8 irq cleared", irq, 0);
        drain("R9 remaining byte");
        rd_byte(); @(negedge clk);
        chk("R9 underflow set", st_underflow, 1);
        chk("R9 data held", buf_data, 8'h33);
        read_stat();
        chk("R8 underflow cleared", st_underflow, 0);

        // R5 header search, valid check byte
        wr_task(2'd2, 1'b0, 1'b0);
        send_byte(8'hFF, 0); send_byte(8'h00, 0);
        send_byte(8'hA5, 0); send_byte(8'h3C, 0);
        chk("R2 no irq before header", irq, 0);
        send_byte(8'h83, 1); send_byte(8'h41, 1); send_byte(8'hC2, 0);
        chk("R5 irq", irq, 1);
        chk("R5 ftype", st_ftype, 1);
        chk("R5 hdr ok", st_hdr_ok, 1);
        read_stat();
        drain("R5 header bytes");

        // R5 header with bad check byte
        wr_task(2'd2, 1'b0, 1'b0);
        send_byte(8'hA5, 0); send_byte(8'h3C, 0);
        send_byte(8'h05, 1); send_byte(8'h06, 1); send_byte(8'h00, 0);
        chk("R5 irq bad", irq, 1);
        chk("R5 ftype clear", st_ftype, 0);
        chk("R5 hdr bad", st_hdr_ok, 0);
        read_stat();
        drain("R5 bad header bytes");

        // R6 good data block, then R7 idle afterwards
        fill_blk(3);
        wr_task(2'd3, 1'b0, 1'b0);
        for (int i = 0; i < 18; i++) send_byte(blk[i], 1);
        chk("R6 irq", irq, 1);
        chk("R6 crc ok", st_crc_ok, 1);
        read_stat();
        send_byte(8'hAA, 0); send_byte(8'h55, 0);
        chk("R7 no irq when idle", irq, 0);
        drain("R6 block bytes");
        rd_byte(); @(negedge clk);
        chk("R7 nothing pushed when idle", st_underflow, 1);
        read_stat();

        // R6 corrupted block
        fill_blk(9);
        blk[4] = blk[4] ^ 8'h10;
        wr_task(2'd3, 1'b0, 1'b0);
        for (int i = 0; i < 18; i++) send_byte(blk[i], 1);
        chk("R6 irq bad", irq, 1);
        chk("R6 crc bad", st_crc_ok, 0);
        read_stat();
        drain("R6 bad block bytes");

        // R3 abort running block with a new block task
        fill_blk(21);
        wr_task(2'd3, 1'b0, 1'b0);
        send_byte(8'hDE, 1); send_byte(8'hAD, 1); send_byte(8'hBE, 1);
        wr_task(2'd3, 1'b0, 1'b0);
        for (int i = 0; i < 18; i++) send_byte(blk[i], 1);
        chk("R3 irq after restart", irq, 1);
        chk("R3 crc ok after restart", st_crc_ok, 1);
        read_stat();
        drain("R3 abort bytes");

        // R10 carrier loss during header search
        wr_task(2'd2, 1'b0, 1'b0);
        repeat (5) send_bit(1'b1);
        carrier_det = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 lost set", st_carrier_lost, 1);
        chk("R10 no irq", irq, 0);
        carrier_det = 1'b1;
        send_byte(8'hA5, 0); send_byte(8'h3C, 0);
        send_byte(8'h83, 0); send_byte(8'h41, 0); send_byte(8'hC2, 0);
        chk("R10 idle after loss", irq, 0);
        rd_byte(); @(negedge clk);
        chk("R10 nothing pushed", st_underflow, 1);
        read_stat();
        chk("R8 lost cleared", st_carrier_lost, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule